// File: doc/BRIEF.md
# SIMD Rounding Average Unit

The unit takes two 128-bit source vectors and returns a 128-bit vector in which every lane holds the rounded average of the two matching source lanes. The result is computed as the sum of the lanes plus one, shifted right by one bit. The sum is formed one bit wider than the lane, so it never overflows. The exact average always fits back into the lane. Rounding therefore goes half-up, toward positive infinity. The unit never produces a saturation or status flag.

Two mode inputs select how the lanes are read. One chooses signed (sign-extended) or unsigned (zero-extended) operands. The other chooses 8-bit, 16-bit or 32-bit lanes. The main use is four signed 32-bit lanes. Lanes are numbered from the most-significant end of the vector.

A small decoder sits beside the datapath. It recognises the 32-bit instruction word for the signed-word average and supplies the mode and the three register indices from that word. A parameter selects the output timing: either the result is combinational, or it is captured one clock after a valid input strobe.

Top module: `simd_avg_unit`

## Requirements
- R1: In signed mode with word lanes (`mode_width`=2), every 32-bit lane of `result` equals floor((A+B+1)/2) of the sign-extended source lanes, with no overflow. This holds at the extremes as well, for example both operands -2^31, or both +2^31-1, or one operand at each extreme.
- R2: Rounding is half-up toward positive infinity: avg(-1,0)=0, avg(1,2)=2, avg(-3,-2)=-2, avg(-2,-1)=-1.
- R3: Lane 0 occupies `result[127:96]` and is computed only from `src_a[127:96]` and `src_b[127:96]`. No carry or sign crosses a lane boundary.
- R4: When `mode_signed`=0, the operands are zero-extended before the same rounding formula is applied. For example, avg(0xFFFFFFFF,0xFFFFFFFF)=0xFFFFFFFF and avg(0xFFFFFFFF,0)=0x80000000.
- R5: `mode_width` encodes the lane size: 0 gives 16 lanes of 8 bits, 1 gives 8 lanes of 16 bits, and 2 or 3 give 4 lanes of 32 bits. Each lane follows R1/R4 at its own width.
- R6: `dec_valid` is 1 only when `instr_word[31:26]`=4 and `instr_word[10:0]`=1410. Under that condition `dec_signed`=1 and `dec_width`=2. Otherwise `dec_valid`=0, `dec_signed`=0 and `dec_width`=0.
- R7: The decoder outputs the destination index `dec_rd`=`instr_word[25:21]`, source A `dec_ra`=`instr_word[20:16]` and source B `dec_rb`=`instr_word[15:11]`. Equal indices are allowed. The full word with all index fields zero is 0x10000582.
- R8: With `REG_OUT`=1, `out_valid` and `result` appear on the clock edge after `in_valid`=1. While `in_valid`=0, `result` holds its last value even if the sources change.
- R9: With `REG_OUT`=0, `result` follows the inputs in the same cycle and `out_valid` equals `in_valid`.
- R10: With `REG_OUT`=1, synchronous reset clears `out_valid` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source operands valid strobe |
| mode_signed | input | 1 | 1 = sign-extend lanes, 0 = zero-extend |
| mode_width | input | 2 | Lane size code (0 byte, 1 half, 2/3 word) |
| src_a | input | VEC_W | Source vector A |
| src_b | input | VEC_W | Source vector B |
| out_valid | output | 1 | Result valid |
| result | output | VEC_W | Rounded lane averages |
| instr_word | input | 32 | Instruction word to decode |
| dec_valid | output | 1 | Word is the signed-word average |
| dec_signed | output | 1 | Decoded signedness |
| dec_width | output | 2 | Decoded lane size code |
| dec_rd | output | 5 | Destination register index |
| dec_ra | output | 5 | Source A register index |
| dec_rb | output | 5 | Source B register index |

## Verification
The bench builds two copies with the default 128-bit vector: `REG_OUT`=1 and `REG_OUT`=0. Driving both copies with the same operands lets it check the one-cycle capture and hold behaviour against the same-cycle path. The 128-bit width with the lane sizes covers every mode. Directed extremes and sign-boundary pairs are applied first. Seeded random vectors in all signedness/width combinations follow, each compared against a 64-bit per-lane reference. Decoder words with random index fields and single-bit opcode corruptions check acceptance and rejection.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

    typedef enum logic [1:0] {
        AVG_B8   = 2'd0,
        AVG_H16  = 2'd1,
        AVG_W32  = 2'd2,
        AVG_W32X = 2'd3
    } avg_width_e;

    typedef struct packed {
        logic       is_signed;
        avg_width_e width;
    } avg_mode_t;

    typedef struct packed {
        logic [5:0]  primary;
        logic [4:0]  rd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [10:0] ext;
    } vx_word_t;

    localparam logic [5:0]  OPC_PRIMARY = 6'd4;
    localparam logic [10:0] OPC_AVG_SW  = 11'd1410;

    function automatic logic is_word_width(avg_width_e w);
        return (w == AVG_W32) || (w == AVG_W32X);
    endfunction

endpackage

// File: rtl/simd_avg_decode.sv
module simd_avg_decode
    import simd_avg_pkg::*;
(
    input  logic [31:0] instr_word,
    output logic        dec_valid,
    output avg_mode_t   dec_mode,
    output logic [4:0]  dec_rd,
    output logic [4:0]  dec_ra,
    output logic [4:0]  dec_rb
);
    vx_word_t fields;

    always_comb begin
        fields    = vx_word_t'(instr_word);
        dec_valid = (fields.primary == OPC_PRIMARY) && (fields.ext == OPC_AVG_SW);
        dec_mode  = '{is_signed: 1'b0, width: AVG_B8};
        if (dec_valid) begin
            dec_mode = '{is_signed: 1'b1, width: AVG_W32};
        end
        dec_rd = fields.rd;
        dec_ra = fields.ra;
        dec_rb = fields.rb;
    end

endmodule

// File: rtl/simd_avg_lanes.sv
module simd_avg_lanes #(
    parameter int VEC_W = 128,
    parameter int LW    = 32
) (
    input  logic             is_signed,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] res
);
    localparam int NLANES = VEC_W / LW;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LW-1:0] la, lb;
        logic [LW:0]   sum;
        assign la  = a[g*LW +: LW];
        assign lb  = b[g*LW +: LW];
        // one extra bit: the widened sum of two lanes plus one never wraps
        assign sum = {is_signed & la[LW-1], la} + {is_signed & lb[LW-1], lb} + {{LW{1'b0}}, 1'b1};
        assign res[g*LW +: LW] = sum[LW:1];
    end

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
    import simd_avg_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             mode_signed,
    input  logic [1:0]       mode_width,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    input  logic [31:0]      instr_word,
    output logic             dec_valid,
    output logic             dec_signed,
    output logic [1:0]       dec_width,
    output logic [4:0]       dec_rd,
    output logic [4:0]       dec_ra,
    output logic [4:0]       dec_rb
);
    avg_mode_t        mode;
    avg_mode_t        dmode;
    logic [VEC_W-1:0] res_b8, res_h16, res_w32, res_sel;

    assign mode = '{is_signed: mode_signed, width: avg_width_e'(mode_width)};

    simd_avg_decode u_dec (
        .instr_word (instr_word),
        .dec_valid  (dec_valid),
        .dec_mode   (dmode),
        .dec_rd     (dec_rd),
        .dec_ra     (dec_ra),
        .dec_rb     (dec_rb)
    );
    assign dec_signed = dmode.is_signed;
    assign dec_width  = dmode.width;

    simd_avg_lanes #(.VEC_W(VEC_W), .LW(8)) u_b8 (
        .is_signed (mode.is_signed), .a(src_a), .b(src_b), .res(res_b8));
    simd_avg_lanes #(.VEC_W(VEC_W), .LW(16)) u_h16 (
        .is_signed (mode.is_signed), .a(src_a), .b(src_b), .res(res_h16));
    simd_avg_lanes #(.VEC_W(VEC_W), .LW(32)) u_w32 (
        .is_signed (mode.is_signed), .a(src_a), .b(src_b), .res(res_w32));

    always_comb begin
        unique case (mode.width)
            AVG_B8:  res_sel = res_b8;
            AVG_H16: res_sel = res_h16;
            default: res_sel = res_w32;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                result    <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result <= res_sel;
                end
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = res_sel;
    end

endmodule

// File: rtl/simd_avg_chk.sv
module simd_avg_chk #(
    parameter int VEC_W   = 128,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             mode_signed,
    input logic [1:0]       mode_width,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] result,
    input logic             dec_valid,
    input logic             dec_signed,
    input logic [1:0]       dec_width
);
    localparam int NW = VEC_W / 32;

    logic [VEC_W-1:0] ck_a, ck_b;
    logic             ck_sw;
    logic             ck_act;

    if (REG_OUT) begin : g_cap
        logic [VEC_W-1:0] pa, pb;
        logic             psw;
        always_ff @(posedge clk) begin
            if (rst) begin
                pa <= '0; pb <= '0; psw <= 1'b0;
            end else if (in_valid) begin
                pa  <= src_a;
                pb  <= src_b;
                psw <= mode_signed && mode_width[1];
            end
        end
        assign ck_a = pa; assign ck_b = pb; assign ck_sw = psw;
        assign ck_act = out_valid;

        // R8
        out_valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        // R8
        result_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(result));
    end else begin : g_nocap
        assign ck_a = src_a; assign ck_b = src_b;
        assign ck_sw = mode_signed && mode_width[1];
        assign ck_act = in_valid;

        // R9
        out_valid_same_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
    end

    for (genvar i = 0; i < NW; i++) begin : g_w
        logic signed [31:0] wa, wb, wr, lo, hi;
        assign wa = ck_a[i*32 +: 32];
        assign wb = ck_b[i*32 +: 32];
        assign wr = result[i*32 +: 32];
        assign lo = (wa < wb) ? wa : wb;
        assign hi = (wa < wb) ? wb : wa;
        // R1
        avg_in_range_chk: assert property (@(posedge clk) disable iff (rst)
            (ck_act && ck_sw) |-> (wr >= lo && wr <= hi));
        // R1
        avg_equal_ops_chk: assert property (@(posedge clk) disable iff (rst)
            (ck_act && ck_sw && wa == wb) |-> (wr == wa));
    end

    // R6
    dec_mode_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_signed && dec_width == 2'd2));
    // R6
    dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!dec_signed && dec_width == 2'd0));

endmodule

bind simd_avg_unit simd_avg_chk #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .mode_signed (mode_signed),
    .mode_width  (mode_width),
    .src_a       (src_a),
    .src_b       (src_b),
    .out_valid   (out_valid),
    .result      (result),
    .dec_valid   (dec_valid),
    .dec_signed  (dec_signed),
    .dec_width   (dec_width)
);

// File: tb/simd_avg_unit_tb_top.sv
`timescale 1ns/1ps
module simd_avg_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         mode_signed = 1'b1;
    logic [1:0]   mode_width = 2'd2;
    logic [127:0] src_a = '0, src_b = '0;
    logic [31:0]  instr_word = '0;

    logic         ov_r, ov_c, dv_r, dv_c, ds_r, ds_c;
    logic [127:0] res_r, res_c;
    logic [1:0]   dw_r, dw_c;
    logic [4:0]   rd_r, ra_r, rb_r, rd_c, ra_c, rb_c;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    simd_avg_unit #(.VEC_W(128), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_signed(mode_signed),
        .mode_width(mode_width), .src_a(src_a), .src_b(src_b),
        .out_valid(ov_r), .result(res_r), .instr_word(instr_word),
        .dec_valid(dv_r), .dec_signed(ds_r), .dec_width(dw_r),
        .dec_rd(rd_r), .dec_ra(ra_r), .dec_rb(rb_r));

    simd_avg_unit #(.VEC_W(128), .REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_signed(mode_signed),
        .mode_width(mode_width), .src_a(src_a), .src_b(src_b),
        .out_valid(ov_c), .result(res_c), .instr_word(instr_word),
        .dec_valid(dv_c), .dec_signed(ds_c), .dec_width(dw_c),
        .dec_rd(rd_c), .dec_ra(ra_c), .dec_rb(rb_c));

    function automatic logic [127:0] ref_avg(input logic [127:0] a, input logic [127:0] b,
                                             input logic s, input logic [1:0] w);
        int lw;
        int n;
        logic [127:0] r;
        longint mask;
        lw = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
        n = 128 / lw;
        r = '0;
        mask = (longint'(1) << lw) - 1;
        for (int i = 0; i < n; i++) begin
            longint x, y, z;
            x = longint'(a[i*32/(32/lw) +: 32] & 32'hFFFFFFFF) & mask;
            y = longint'(b[i*32/(32/lw) +: 32] & 32'hFFFFFFFF) & mask;
            if (s && x[lw-1]) x = x - (longint'(1) << lw);
            if (s && y[lw-1]) y = y - (longint'(1) << lw);
            z = (x + y + 1) >>> 1;
            r = r | (128'(z & mask) << (i*lw));
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply one vector: check same-cycle copy, then registered copy after the edge
    task automatic apply(input string req, input logic [127:0] a, input logic [127:0] b,
                         input logic s, input logic [1:0] w);
        logic [127:0] e;
        e = ref_avg(a, b, s, w);
        @(negedge clk);
        src_a = a; src_b = b; mode_signed = s; mode_width = w; in_valid = 1'b1;
        #1;
        chk({req, " R9 comb"}, res_c, e);
        chk({req, " R9 comb valid"}, {127'd0, ov_c}, 128'd1);
        @(posedge clk); #1;
        chk({req, " R8 reg"}, res_r, e);
        chk({req, " R8 reg valid"}, {127'd0, ov_r}, 128'd1);
    endtask

    function automatic logic [127:0] w4(input logic [31:0] l0, input logic [31:0] l1,
                                        input logic [31:0] l2, input logic [31:0] l3);
        return {l0, l1, l2, l3};
    endfunction

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 reset result", res_r, '0);
        chk("R10 reset valid", {127'd0, ov_r}, '0);
        @(negedge clk); rst = 1'b0;

        // R1 extremes
        apply("R1 extremes", w4(32'h80000000, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF),
                             w4(32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h80000000), 1'b1, 2'd2);
        chk("R1 both min", res_r[127:96], 128'h80000000);
        chk("R1 opposite", res_r[63:32], 128'h0);
        // R2 half-up
        apply("R2 round", w4(32'hFFFFFFFF, 32'd1, 32'hFFFFFFFD, 32'hFFFFFFFE),
                          w4(32'd0, 32'd2, 32'hFFFFFFFE, 32'hFFFFFFFF), 1'b1, 2'd2);
        chk("R2 round explicit", res_r, w4(32'd0, 32'd2, 32'hFFFFFFFE, 32'hFFFFFFFF));
        // R3 lane 0 only
        apply("R3 lane0", w4(32'h00000064, 0, 0, 32'hFFFFFFFF), w4(32'h000000C8, 0, 0, 32'hFFFFFFFF), 1'b1, 2'd2);
        chk("R3 lane0 position", res_r, w4(32'd150, 0, 0, 32'hFFFFFFFF));
        // R4 unsigned
        apply("R4 unsigned", w4(32'hFFFFFFFF, 32'hFFFFFFFF, 32'd3, 32'd0),
                             w4(32'hFFFFFFFF, 32'd0, 32'd4, 32'd0), 1'b0, 2'd2);
        chk("R4 unsigned explicit", res_r, w4(32'hFFFFFFFF, 32'h80000000, 32'd4, 32'd0));
        // R5 widths
        apply("R5 byte", {16{8'h80}}, {16{8'h7F}}, 1'b1, 2'd0);
        chk("R5 byte explicit", res_r, {16{8'h00}});
        apply("R5 half", {8{16'hFFFF}}, {8{16'h0001}}, 1'b0, 2'd1);
        chk("R5 half explicit", res_r, {8{16'h8000}});
        apply("R5 code3", w4(32'hFFFFFFFF, 1, 2, 3), w4(32'd0, 2, 5, 7), 1'b1, 2'd3);

        // random sweep over all modes
        for (int k = 0; k < 400; k++) begin
            logic [127:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            if (k % 7 == 0) b = a;
            apply("R5 random", a, b, 1'($urandom), 2'($urandom));
        end

        // R8 hold while in_valid low
        held = res_r;
        @(negedge clk);
        in_valid = 1'b0; src_a = ~src_a; src_b = {4{32'h12345678}};
        @(posedge clk); #1;
        chk("R8 hold result", res_r, held);
        chk("R8 valid drop", {127'd0, ov_r}, '0);
        chk("R9 comb valid low", {127'd0, ov_c}, '0);

        // R6/R7 decoder
        instr_word = 32'h10000582; #1;
        chk("R6 base word", {dv_r, ds_r, dw_r}, 128'b1110);
        chk("R7 zero fields", {rd_r, ra_r, rb_r}, '0);
        for (int k = 0; k < 40; k++) begin
            logic [4:0] d, a, b;
            d = 5'($urandom); a = 5'($urandom); b = (k % 4 == 0) ? d : 5'($urandom);
            instr_word = {6'd4, d, a, b, 11'd1410}; #1;
            chk("R6 accept", {dv_r, ds_r, dw_r}, 128'b1110);
            chk("R7 fields", {rd_r, ra_r, rb_r}, {d, a, b});
            instr_word = instr_word ^ (32'h1 << ((k % 2 == 0) ? (26 + (k/2) % 6) : (k/2) % 11)); #1;
            chk("R6 reject", {dv_r, ds_r, dw_r}, '0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule